// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table that lives in memory. Software loads a directory base register whenever a different process is scheduled. Each translation request then starts a walk that uses the base value present in the cycle the request is accepted. The walk makes one memory read for the directory entry. The frame field of that entry gives the base of a second-level table. The walk then reads the table entry, whose frame field gives the physical page frame.

Both levels are checked for the present bit. A cleared bit at either level ends the walk at once with a page fault. The fault carries vector 14, the faulting virtual address and the level that was missing. A successful walk returns the frame joined with the page offset, plus write and user permissions. These permissions are the AND of the flags at both levels.

Memory is reached through a read port with a valid/ready request and a response strobe. Only one read is ever outstanding, and the response latency may be any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `req_ack`, `mem_rd_valid` and `res_valid` are 0. The base register resets to 0.
- R2: `req_ack` is high in the cycle that `req_valid` is high and no walk is in progress. `busy` is high from the next cycle up to and including the single cycle in which `res_valid` is high, and is low in the cycle after that.
- R3: The first read address is the base register with its low 12 bits cleared, plus 4 times the directory index taken from virtual address bits 31:22.
- R4: When the directory entry has bit 0 (present) set, the second read address is directory-entry bits 31:12 followed by twelve zeros, plus 4 times the table index taken from virtual address bits 21:12.
- R5: On success, `res_paddr` is table-entry bits 31:12 joined with virtual address bits 11:0.
- R6: On success, `res_writable` is the AND of bit 1 of both entries, and `res_user` is the AND of bit 2 of both entries. Entry bits 11:3 have no effect.
- R7: A cleared present bit gives a fault result. In that result `res_fault` is 1 and `res_fault_vector` is 14. `res_fault_vaddr` is the request address. `res_fault_level` is 0 for the directory and 1 for the table. `res_paddr`, `res_writable` and `res_user` are all 0. A successful result has a fault vector of 0 and a fault address of 0.
- R8: `mem_rd_valid` is high only during a walk. Once raised, it stays high with a stable address until `mem_rd_ready` is sampled high. No new read is issued before the response to the previous read has arrived.
- R9: A base write takes only address bits 31:12. A write made while a walk is running does not change the addresses of that walk. It applies to the next walk.
- R10: A walk that faults at the directory level makes exactly one read. Every other walk makes exactly two reads.
- R11: While a walk is in progress, `req_ack` stays 0 even when `req_valid` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Load strobe for the directory base register |
| base_wr_data | input | 32 | New directory base; bits 11:0 are ignored |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_resp_valid | input | 1 | Read data is valid |
| mem_resp_data | input | 32 | Entry returned by memory |
| res_valid | output | 1 | One-cycle strobe marking a finished walk |
| res_fault | output | 1 | Walk ended with a page fault |
| res_paddr | output | 32 | Translated physical address (0 on fault) |
| res_writable | output | 1 | Combined write permission |
| res_user | output | 1 | Combined user permission |
| res_fault_vaddr | output | 32 | Virtual address that faulted |
| res_fault_level | output | 1 | 0: directory entry absent, 1: table entry absent |
| res_fault_vector | output | 8 | 14 on a fault, 0 otherwise |

## Verification
The bench sweeps directory and table indices, including 0 and 1023, against a computed memory image. In that image absent entries occur at both levels, and the spare bits 11:3 of every entry hold noise. A walker that forgot to scale the index by four, or that kept the low base bits, would read the wrong entry and give a wrong frame. A walker that combined permissions with OR, or took them from one level only, would report a writable or user page where the other level forbids it. Random ready stalls and response latencies expose a read address that moves while stalled, or a second read issued before its response. A base write in the middle of a walk, and a request held high through a walk, catch a walker that tracks the live base register or accepts a request while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int VA_W        = 32;
  localparam int OFF_W       = 12;
  localparam int IDX_W       = (VA_W - OFF_W) / 2;
  localparam int FRAME_W     = VA_W - OFF_W;
  localparam int ENTRY_SHIFT = 2;
  localparam int SPARE_W     = OFF_W - 3;
  localparam int VEC_W       = 8;
  localparam logic [VEC_W-1:0] PF_VECTOR = VEC_W'(14);

  typedef enum logic [1:0] {W_IDLE, W_DIR, W_TBL, W_DONE} walk_state_t;
  typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_WAIT} port_state_t;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [SPARE_W-1:0] spare;
    logic               user;
    logic               writable;
    logic               present;
  } entry_t;

  function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  // byte address of entry idx in the table whose frame is table_frame
  function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] table_frame,
                                                 input logic [IDX_W-1:0]   idx);
    logic [VA_W-1:0] scaled;
    scaled = VA_W'(idx) << ENTRY_SHIFT;
    return {table_frame, {OFF_W{1'b0}}} + scaled;
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [VA_W-1:0]    va);
    return {frame, va[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg import ptw_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VA_W-1:0]    wr_data,
  output logic [FRAME_W-1:0] base_frame
);

  // only the frame part is stored; the offset bits of a write are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_frame <= '0;
    else if (wr_en) base_frame <= wr_data[VA_W-1:OFF_W];
  end

endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port import ptw_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VA_W-1:0] start_addr,
  output logic            rd_valid,
  output logic [VA_W-1:0] rd_addr,
  input  logic            rd_ready,
  input  logic            resp_valid,
  input  logic [VA_W-1:0] resp_data,
  output logic            got,
  output logic [VA_W-1:0] got_data
);

  port_state_t phase_q, phase_d;
  logic        ev_handshake;
  logic        ev_start_ok;

  assign rd_valid     = (phase_q == P_ISSUE);
  assign ev_handshake = rd_valid && rd_ready;
  assign got          = (phase_q == P_WAIT) && resp_valid;
  assign got_data     = resp_data;
  assign ev_start_ok  = (phase_q == P_IDLE) || got;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      P_IDLE:  if (start)        phase_d = P_ISSUE;
      P_ISSUE: if (ev_handshake) phase_d = P_WAIT;
      P_WAIT:  if (resp_valid)   phase_d = start ? P_ISSUE : P_IDLE;
      default:                   phase_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      rd_addr <= '0;
    end else begin
      phase_q <= phase_d;
      if (start && ev_start_ok) rd_addr <= start_addr;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R8
  AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ev_start_ok); // R8

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic               got,
  input  logic [VA_W-1:0]    got_data,
  output logic               req_ack,
  output logic               busy,
  output logic               start,
  output logic [VA_W-1:0]    start_addr,
  output logic               res_valid,
  output logic               res_fault,
  output logic [VA_W-1:0]    res_paddr,
  output logic               res_writable,
  output logic               res_user,
  output logic [VA_W-1:0]    res_fault_vaddr,
  output logic               res_fault_level,
  output logic [VEC_W-1:0]   res_fault_vector
);

  walk_state_t     state_q, state_d;
  logic [VA_W-1:0] va_q;
  logic            pde_wr_q, pde_us_q;
  entry_t          ent;

  // named walk events
  logic ev_accept, ev_dir_hit, ev_dir_miss, ev_tbl_got, ev_tbl_miss, ev_tbl_ok;

  assign ent         = entry_t'(got_data);
  assign ev_accept   = (state_q == W_IDLE) && req_valid;
  assign ev_dir_hit  = (state_q == W_DIR) && got && ent.present;
  assign ev_dir_miss = (state_q == W_DIR) && got && !ent.present;
  assign ev_tbl_got  = (state_q == W_TBL) && got;
  assign ev_tbl_miss = ev_tbl_got && !ent.present;
  assign ev_tbl_ok   = ev_tbl_got && ent.present;

  assign req_ack   = ev_accept;
  assign busy      = (state_q != W_IDLE);
  assign res_valid = (state_q == W_DONE);
  assign start     = ev_accept || ev_dir_hit;
  assign start_addr = (state_q == W_IDLE) ? entry_addr(base_frame, dir_index(req_vaddr))
                                          : entry_addr(ent.frame, tbl_index(va_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      W_IDLE: if (ev_accept) state_d = W_DIR;
      W_DIR: begin
        if (ev_dir_hit)       state_d = W_TBL;
        else if (ev_dir_miss) state_d = W_DONE;
      end
      W_TBL:  if (ev_tbl_got) state_d = W_DONE;
      W_DONE: state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      va_q     <= '0;
      pde_wr_q <= 1'b0;
      pde_us_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) va_q <= req_vaddr;
      if (ev_dir_hit) begin
        pde_wr_q <= ent.writable;
        pde_us_q <= ent.user;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault        <= 1'b0;
      res_paddr        <= '0;
      res_writable     <= 1'b0;
      res_user         <= 1'b0;
      res_fault_vaddr  <= '0;
      res_fault_level  <= 1'b0;
      res_fault_vector <= '0;
    end else if (ev_dir_miss || ev_tbl_miss) begin
      res_fault        <= 1'b1;
      res_paddr        <= '0;
      res_writable     <= 1'b0;
      res_user         <= 1'b0;
      res_fault_vaddr  <= va_q;
      res_fault_level  <= ev_tbl_miss;
      res_fault_vector <= PF_VECTOR;
    end else if (ev_tbl_ok) begin
      res_fault        <= 1'b0;
      res_paddr        <= join_pa(ent.frame, va_q);
      res_writable     <= pde_wr_q & ent.writable;
      res_user         <= pde_us_q & ent.user;
      res_fault_vaddr  <= '0;
      res_fault_level  <= 1'b0;
      res_fault_vector <= '0;
    end
  end

  AST_ACK_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && !busy); // R2
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0 && res_fault_vector == PF_VECTOR); // R7
  AST_TBL_AFTER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tbl_got |-> $past(state_q) == W_TBL); // R4

endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_wr,
  input  logic [VA_W-1:0]    base_wr_data,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               req_ack,
  output logic               busy,
  output logic               mem_rd_valid,
  output logic [VA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_ready,
  input  logic               mem_resp_valid,
  input  logic [VA_W-1:0]    mem_resp_data,
  output logic               res_valid,
  output logic               res_fault,
  output logic [VA_W-1:0]    res_paddr,
  output logic               res_writable,
  output logic               res_user,
  output logic [VA_W-1:0]    res_fault_vaddr,
  output logic               res_fault_level,
  output logic [VEC_W-1:0]   res_fault_vector
);

  logic [FRAME_W-1:0] base_frame;
  logic               start, got;
  logic [VA_W-1:0]    start_addr, got_data;

  ptw_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr), .wr_data(base_wr_data),
    .base_frame(base_frame)
  );

  ptw_mem_port u_port (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr), .rd_ready(mem_rd_ready),
    .resp_valid(mem_resp_valid), .resp_data(mem_resp_data),
    .got(got), .got_data(got_data)
  );

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .base_frame(base_frame), .got(got), .got_data(got_data),
    .req_ack(req_ack), .busy(busy), .start(start), .start_addr(start_addr),
    .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
    .res_writable(res_writable), .res_user(res_user),
    .res_fault_vaddr(res_fault_vaddr), .res_fault_level(res_fault_level),
    .res_fault_vector(res_fault_vector)
  );

  AST_RD_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> busy); // R8
  AST_OK_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_fault_vector == '0 && res_fault_vaddr == '0); // R7
  AST_NO_ACK_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ack); // R11

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  localparam logic [19:0] B1F = 20'h00003;
  localparam logic [19:0] B2F = 20'h00005;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ack, busy, mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic        res_valid, res_fault, res_writable, res_user, res_fault_level;
  logic [31:0] res_paddr, res_fault_vaddr;
  logic [7:0]  res_fault_vector;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ack(req_ack), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
    .res_writable(res_writable), .res_user(res_user),
    .res_fault_vaddr(res_fault_vaddr), .res_fault_level(res_fault_level),
    .res_fault_vector(res_fault_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // computed memory image: two directories, tables above 0x0100_0000
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [9:0]  i, j;
    logic        sel;
    logic [31:0] w, sum;
    w = 32'hFFFF_FFF0;
    if (a >= 32'h0100_0000) begin
      sel = a[22]; i = a[21:12]; j = a[11:2];
      sum = {22'd0, i} * 32'd613 + {22'd0, j} * 32'd97 + (sel ? 32'd4099 : 32'd0);
      w[31:12] = sum[19:0];
      w[11:3]  = j[8:0];
      w[2]     = j[1];
      w[1]     = j[0];
      w[0]     = ((({22'd0, i} + {22'd0, j} + {31'd0, sel}) % 32'd5) != 32'd2);
    end else if (a[31:12] == B1F || a[31:12] == B2F) begin
      sel = (a[31:12] == B2F); i = a[11:2];
      w[31:12] = {8'h01, 1'b0, sel, i};
      w[11:3]  = ~i[8:0];
      w[2]     = i[2];
      w[1]     = ~i[0];
      w[0]     = (({22'd0, i} % 32'd7) != (sel ? 32'd5 : 32'd3));
    end
    return w;
  endfunction

  // memory responder with pseudo-random stalls and latency
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] rd_log [0:3];
  int          rd_cnt = 0;
  bit          pend = 1'b0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  int          port_err = 0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_resp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 1) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = mem_word(pend_addr);
          pend = 1'b0;
        end else pend_cnt--;
      end
      if (prev_stall && (!mem_rd_valid || mem_rd_addr != prev_addr)) port_err++; // R8
      mem_rd_ready = (lfsr[2:1] != 2'b00);
      if (mem_rd_valid && (pend || mem_resp_valid)) port_err++;                // R8
      if (mem_rd_valid && mem_rd_ready) begin
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        pend = 1'b1;
        pend_cnt = int'(lfsr[5:4]) + 1;
        pend_addr = mem_rd_addr;
      end
      prev_stall = mem_rd_valid && !mem_rd_ready;
      prev_addr  = mem_rd_addr;
    end
  end

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_wr_data = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [19:0] bf,
                         input bit hold, input bit swap, input logic [31:0] swap_val);
    logic [31:0] dir_a, tbl_a, pde, pte, exp_pa;
    bit          p1, flt;
    int          n;
    dir_a = {bf, 12'h000} + {20'd0, va[31:22], 2'b00};
    pde   = mem_word(dir_a);
    p1    = pde[0];
    tbl_a = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    pte   = mem_word(tbl_a);
    flt   = !p1 || !pte[0];
    exp_pa = flt ? 32'd0 : {pte[31:12], va[11:0]};
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    #1 chk(req_ack === 1'b1, "R2 ack when idle", {31'd0, req_ack}, 32'd1);
    @(negedge clk);
    if (swap) begin base_wr = 1'b1; base_wr_data = swap_val; end
    chk(busy === 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
    if (hold) begin
      chk(req_ack === 1'b0, "R11 no ack while busy", {31'd0, req_ack}, 32'd0);
      @(negedge clk);
      base_wr = 1'b0;
      chk(req_ack === 1'b0, "R11 no ack while busy", {31'd0, req_ack}, 32'd0);
    end
    if (!swap || !hold) begin
      @(negedge clk);
      base_wr = 1'b0;
    end
    req_valid = 1'b0;
    n = 0;
    while (res_valid !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) begin
      chk(1'b0, "R2 walk did not finish", 32'd0, 32'd1);
      return;
    end
    chk(busy === 1'b1, "R2 busy with result", {31'd0, busy}, 32'd1);
    chk(rd_cnt == (p1 ? 2 : 1), "R10 read count", 32'(rd_cnt), p1 ? 32'd2 : 32'd1);
    chk(rd_log[0] === dir_a, "R3 directory address", rd_log[0], dir_a);
    if (p1) chk(rd_log[1] === tbl_a, "R4 table address", rd_log[1], tbl_a);
    chk(res_fault === flt, "R7 fault flag", {31'd0, res_fault}, {31'd0, flt});
    chk(res_paddr === exp_pa, "R5 physical address", res_paddr, exp_pa);
    if (flt) begin
      chk(res_fault_vector === 8'd14, "R7 vector", {24'd0, res_fault_vector}, 32'd14);
      chk(res_fault_vaddr === va, "R7 fault address", res_fault_vaddr, va);
      chk(res_fault_level === p1, "R7 fault level", {31'd0, res_fault_level}, {31'd0, p1});
      chk({res_writable, res_user} === 2'b00, "R7 flags cleared", {30'd0, res_writable, res_user}, 32'd0);
    end else begin
      chk(res_fault_vector === 8'd0 && res_fault_vaddr === 32'd0, "R7 no fault info",
          res_fault_vaddr, 32'd0);
      chk(res_writable === (pde[1] & pte[1]), "R6 writable", {31'd0, res_writable}, {31'd0, pde[1] & pte[1]});
      chk(res_user === (pde[2] & pte[2]), "R6 user", {31'd0, res_user}, {31'd0, pde[2] & pte[2]});
    end
    @(negedge clk);
    chk(busy === 1'b0 && res_valid === 1'b0, "R2 idle after result", {30'd0, busy, res_valid}, 32'd0);
  endtask

  task automatic sweep(input logic [19:0] bf);
    logic [9:0]  jj;
    logic [31:0] va;
    for (int i = 0; i < 1024; i += 37) begin
      for (int s = 0; s < 5; s++) begin
        case (s)
          0: jj = 10'd0;
          1: jj = 10'd1;
          2: jj = 10'd2;
          3: jj = 10'd1023;
          default: jj = 10'(i * 3);
        endcase
        va = {10'(i), jj, 12'(i * 29 + s * 7)};
        do_walk(va, bf, 1'b0, 1'b0, 32'd0);
      end
    end
    do_walk(32'hFFFF_FFFF, bf, 1'b0, 1'b0, 32'd0);
    do_walk(32'h0000_0000, bf, 1'b0, 1'b0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && req_ack === 1'b0, "R1 reset busy/ack", {30'd0, busy, req_ack}, 32'd0);
    chk(mem_rd_valid === 1'b0 && res_valid === 1'b0, "R1 reset port/result",
        {30'd0, mem_rd_valid, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && res_valid === 1'b0 && mem_rd_valid === 1'b0, "R1 after reset",
        {29'd0, busy, res_valid, mem_rd_valid}, 32'd0);
    // R1: untouched base register reads directory at address 0 onward
    do_walk(32'h0040_1234, 20'd0, 1'b0, 1'b0, 32'd0);
    // R9: offset bits of the base write are dropped
    write_base({B1F, 12'h123});
    sweep(B1F);
    do_walk(32'h00C0_3000, B1F, 1'b0, 1'b0, 32'd0);   // directory index 3 absent (R7)
    // R9: base changed mid-walk only affects the next walk; R11 request held high
    do_walk(32'h0123_4567, B1F, 1'b1, 1'b1, {B2F, 12'hABC});
    do_walk(32'h0123_4567, B2F, 1'b0, 1'b0, 32'd0);
    sweep(B2F);
    do_walk(32'h0140_0000, B2F, 1'b1, 1'b0, 32'd0);   // directory index 5 absent (R7)
    chk(port_err == 0, "R8 read port discipline", 32'(port_err), 32'd0);
    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule